// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block derives the timing of an I2C controller from its core clock. A 7-bit rate word holds two factors: a linear factor M (0 to 15) and an exponent N (0 to 7). A first counter divides the core clock by M+1. A second counter divides that result by 2^(N+1). The second counter emits a one-cycle sampling tick that a byte engine uses to oversample the bus. A third counter groups the sampling ticks in fives. Every fifth tick it raises a toggle strobe and flips an SCL phase level, so one SCL period lasts ten sampling ticks. The resulting bus rate is core clock / (10 × (M+1) × 2^(N+1)).

After reset the rate word holds the factors that give the fastest bus rate not above a target rate. Both the target rate (100 kHz by default) and the core clock frequency are parameters. Writing the rate word or dropping the enable input clears every counter, the tick outputs and the phase. When counting resumes, it starts from a clean period boundary.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset the outputs sampleTick, sclToggle and sclPhase are 0. The rate word holds the search result for the core and bus rates: the factors whose rate is the largest not above the target, with the first such pair kept when the search runs N from 0 upward and M from 0 upward within each N. With the default 100 MHz core clock and 100 kHz target this gives M=12 and N=2. The first sampleTick then appears 104 enabled cycles after reset is released.
- R2: A write with cfgWr high loads cfgData bits 6:3 as M and bits 2:0 as N. Without a write, the rate word keeps its value.
- R3: While enabled and not written, sampleTick is a single-cycle pulse that repeats every (M+1)×2^(N+1) core cycles.
- R4: After the last clock edge that sampled a write or a low enable, the first sampleTick is high following exactly (M+1)×2^(N+1) further enabled edges. No tick appears before that.
- R5: A write in the middle of a run restarts both dividers and the five-tick group, and returns sclPhase to 0.
- R6: While enable is low, sampleTick and sclToggle stay 0 and sclPhase stays 0. A write made while disabled takes effect when enable returns.
- R7: sclToggle pulses in the same cycle as every fifth sampleTick, counting from the restart. sclPhase flips on each toggle, so one SCL period spans ten sampling ticks.
- R8: The extreme settings work: M=0,N=0 gives a period of 2 cycles, and M=15,N=7 gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the dividers when high; clears them when low |
| cfgWr | input | 1 | Loads the rate word from cfgData |
| cfgData | input | 7 | Rate word: bits 6:3 are M, bits 2:0 are N |
| sampleTick | output | 1 | One-cycle sampling strobe at ten times the SCL rate |
| sclToggle | output | 1 | One-cycle strobe on every fifth sampling tick |
| sclPhase | output | 1 | SCL phase level; flips on each toggle |

## Verification
The bench loads every one of the 128 rate words and measures the first-tick latency against (M+1)×2^(N+1). This sweep catches three kinds of error: a divider that is off by one, a divider that swaps the M and N fields, and a divider that decodes 2^N in place of 2^(N+1). At each tick the bench also checks that the pulse lasts one cycle. The toggle and phase pattern is checked over 25 ticks; a group counter that wraps at four or six would misplace the toggle. The bench also writes the rate word in the middle of a period and holds the block disabled for hundreds of cycles. A design that only reloaded the factors, or that merely froze its counters while disabled, would leave a stale phase or deliver a short first period, and these tests expose either fault.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef struct packed {
    logic clear;
    logic run;
  } rateStrb_t;

  // Finds the {M,N} pair giving the fastest rate not above busHz.
  // Result: M in bits 15:8, N in bits 7:0.
  function automatic logic [15:0] pick_factors(longint coreHz, longint busHz,
                                               int mMax, int nMax);
    longint bestDelta;
    longint rate;
    longint delta;
    logic [15:0] best;
    bestDelta = -1;
    best = {mMax[7:0], nMax[7:0]};
    for (int n = 0; n <= nMax; n++) begin
      for (int m = 0; m <= mMax; m++) begin
        rate  = coreHz / (longint'(10) * longint'(m + 1) * (longint'(2) << n));
        delta = busHz - rate;
        if (delta >= 0 && (bestDelta < 0 || delta < bestDelta)) begin
          best      = {m[7:0], n[7:0]};
          bestDelta = delta;
        end
      end
    end
    return best;
  endfunction

endpackage

// File: rtl/scl_rate_ctl.sv
module scl_rate_ctl
  import scl_rate_pkg::*;
#(
  parameter int     M_W     = 4,
  parameter int     N_W     = 3,
  parameter longint CORE_HZ = 100_000_000,
  parameter longint BUS_HZ  = 100_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWr,
  input  logic [M_W+N_W-1:0] cfgData,
  output rateStrb_t          strb,
  output logic [M_W-1:0]     divM,
  output logic [N_W-1:0]     divN
);

  localparam logic [15:0] RST_FAC = pick_factors(CORE_HZ, BUS_HZ,
                                                 (1 << M_W) - 1, (1 << N_W) - 1);
  localparam logic [M_W-1:0] RST_M = RST_FAC[8 +: M_W];
  localparam logic [N_W-1:0] RST_N = RST_FAC[0 +: N_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divM <= RST_M;
      divN <= RST_N;
    end else if (cfgWr) begin
      divM <= cfgData[N_W +: M_W];
      divN <= cfgData[0 +: N_W];
    end
  end

  always_comb begin
    strb.clear = cfgWr | ~enable;
    strb.run   = enable & ~cfgWr;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> $stable({divM, divN}))
    else $error("rate word changed without a write"); // R2

endmodule

// File: rtl/scl_rate_dp.sv
module scl_rate_dp
  import scl_rate_pkg::*;
#(
  parameter int M_W            = 4,
  parameter int N_W            = 3,
  parameter int TICKS_PER_HALF = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  rateStrb_t      strb,
  input  logic [M_W-1:0] divM,
  input  logic [N_W-1:0] divN,
  output logic           sampleTick,
  output logic           sclToggle,
  output logic           sclPhase
);

  localparam int POST_W = 1 << N_W;
  localparam int PH_W   = $clog2(TICKS_PER_HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS_PER_HALF - 1);

  logic [M_W-1:0]    preCnt;
  logic [POST_W-1:0] postCnt;
  logic [POST_W-1:0] postLast;
  logic [PH_W-1:0]   phaseCnt;
  logic              preWrap;
  logic              postWrap;
  logic              tickNow;
  logic              phaseWrap;

  // terminal count of the second stage: 2^(N+1)-1
  for (genvar i = 0; i < POST_W; i++) begin : g_mask
    assign postLast[i] = (i <= int'(divN));
  end

  always_comb begin
    preWrap   = (preCnt == divM);
    postWrap  = (postCnt == postLast);
    tickNow   = strb.run & preWrap & postWrap;
    phaseWrap = (phaseCnt == PH_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      postCnt    <= '0;
      phaseCnt   <= '0;
      sampleTick <= 1'b0;
      sclToggle  <= 1'b0;
      sclPhase   <= 1'b0;
    end else if (strb.clear) begin
      preCnt     <= '0;
      postCnt    <= '0;
      phaseCnt   <= '0;
      sampleTick <= 1'b0;
      sclToggle  <= 1'b0;
      sclPhase   <= 1'b0;
    end else if (strb.run) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (preWrap) begin
        postCnt <= postWrap ? '0 : postCnt + 1'b1;
      end
      sampleTick <= tickNow;
      sclToggle  <= tickNow & phaseWrap;
      if (tickNow) begin
        phaseCnt <= phaseWrap ? '0 : phaseCnt + 1'b1;
        if (phaseWrap) begin
          sclPhase <= ~sclPhase;
        end
      end
    end
  end

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!sampleTick && !sclToggle && !sclPhase))
    else $error("activity after clear"); // R6

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick)
    else $error("tick wider than one cycle"); // R3

  AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sclToggle |-> sampleTick)
    else $error("toggle without tick"); // R7

  AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    sclToggle |-> (sclPhase != $past(sclPhase)))
    else $error("toggle without phase flip"); // R7

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= divM)
    else $error("first stage past its limit"); // R3

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt <= PH_LAST)
    else $error("group counter past its limit"); // R7

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int     M_W            = 4,
  parameter int     N_W            = 3,
  parameter int     TICKS_PER_HALF = 5,
  parameter longint CORE_HZ        = 100_000_000,
  parameter longint BUS_HZ         = 100_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWr,
  input  logic [M_W+N_W-1:0] cfgData,
  output logic               sampleTick,
  output logic               sclToggle,
  output logic               sclPhase
);

  rateStrb_t      strb;
  logic [M_W-1:0] divM;
  logic [N_W-1:0] divN;

  scl_rate_ctl #(
    .M_W(M_W), .N_W(N_W), .CORE_HZ(CORE_HZ), .BUS_HZ(BUS_HZ)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWr(cfgWr),
    .cfgData(cfgData), .strb(strb), .divM(divM), .divN(divN)
  );

  scl_rate_dp #(
    .M_W(M_W), .N_W(N_W), .TICKS_PER_HALF(TICKS_PER_HALF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .divM(divM), .divN(divN),
    .sampleTick(sampleTick), .sclToggle(sclToggle), .sclPhase(sclPhase)
  );

endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic       cfgWr;
  logic [6:0] cfgData;
  logic       sampleTick;
  logic       sclToggle;
  logic       sclPhase;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  scl_rate_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWr(cfgWr), .cfgData(cfgData),
    .sampleTick(sampleTick), .sclToggle(sclToggle), .sclPhase(sclPhase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int m, input int n);
    return (m + 1) * (2 << n);
  endfunction

  task automatic writeCfg(input int m, input int n);
    @(negedge clk);
    cfgWr   = 1'b1;
    cfgData = {m[3:0], n[2:0]};
    @(negedge clk);
    cfgWr   = 1'b0;
  endtask

  task automatic waitTick(output int got, input int limit);
    got = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      got++;
    end while (!sampleTick && got < limit);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 195000);
    check(1'b0, "watchdog", cyc, 0);
    finishRun();
  end

  initial begin
    int got;
    bit expPh;
    rstN = 1'b0; enable = 1'b1; cfgWr = 1'b0; cfgData = '0;
    repeat (3) @(negedge clk);
    check(!sampleTick, "R1 tick at reset", int'(sampleTick), 0);
    check(!sclToggle, "R1 toggle at reset", int'(sclToggle), 0);
    check(!sclPhase, "R1 phase at reset", int'(sclPhase), 0);
    rstN = 1'b1;
    waitTick(got, 120);
    check(got == 104, "R1 default period", got, 104);

    // full sweep of the rate word: latency and pulse width
    for (int m = 0; m < 16; m++) begin
      for (int n = 0; n < 8; n++) begin
        int p;
        p = period(m, n);
        writeCfg(m, n);
        waitTick(got, p + 5);
        if ((m == 0 && n == 0) || (m == 15 && n == 7))
          check(got == p, "R8 extreme latency", got, p);
        else
          check(got == p, "R4 R2 first tick latency", got, p);
        @(posedge clk); @(negedge clk);
        check(!sampleTick, "R3 single-cycle tick", int'(sampleTick), 0);
      end
    end

    // steady period between ticks
    for (int k = 0; k < 4; k++) begin
      int m;
      int n;
      int p;
      m = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 9 : 15;
      n = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 4 : 7;
      p = period(m, n);
      writeCfg(m, n);
      waitTick(got, p + 5);
      waitTick(got, p + 5);
      check(got == p, "R3 tick period", got, p);
    end

    // toggle and phase pattern
    writeCfg(0, 0);
    expPh = 1'b0;
    for (int k = 0; k < 25; k++) begin
      waitTick(got, 10);
      if (k % 5 == 4) expPh = ~expPh;
      check(sclToggle == (k % 5 == 4), "R7 toggle every fifth tick", int'(sclToggle), int'(k % 5 == 4));
      check(sclPhase == expPh, "R7 phase level", int'(sclPhase), int'(expPh));
    end

    // write in the middle of a run
    writeCfg(3, 0);
    for (int k = 0; k < 7; k++) waitTick(got, 12);
    check(sclPhase == 1'b1, "R7 phase after seven ticks", int'(sclPhase), 1);
    repeat (3) @(negedge clk);
    writeCfg(3, 0);
    check(!sclPhase, "R5 phase restarts on write", int'(sclPhase), 0);
    waitTick(got, 20);
    check(got == 8, "R5 full period after write", got, 8);

    // disable gating
    @(negedge clk);
    enable = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 300; k++) begin
        @(posedge clk); @(negedge clk);
        if (sampleTick || sclToggle || sclPhase) seen++;
        if (k == 100) begin
          cfgWr = 1'b1; cfgData = {4'd0, 3'd0};
        end else begin
          cfgWr = 1'b0;
        end
      end
      check(seen == 0, "R6 silent while disabled", seen, 0);
    end
    enable = 1'b1;
    waitTick(got, 20);
    check(got == 2, "R6 write while disabled applies", got, 2);

    finishRun();
  end

endmodule